// File: doc/BRIEF.md
# Dual-Mapped Data Memory with Hardware Stack

This unit is the internal data store of an 8-bit microcontroller core. It holds a 256-byte RAM and a small special-function-register window, and it keeps the stack pointer. The core sends one command at a time: a single-byte read or write, a memory-to-memory move, a push or a pop. The unit answers with a one-cycle response pulse that carries the byte involved.

Addresses 0x80 to 0xFF have two meanings. An indirect access reaches the upper half of the RAM. A direct access reaches the register window. Below 0x80 both modes reach the same lower RAM bytes.

The stack lives in RAM and grows upward. Stack slots are always addressed indirectly through the stack pointer. The byte that is pushed or popped is always named by a direct address. A move copies one byte from a source to a destination, and each operand uses its own addressing mode. Move, push and pop each take a read phase and then a write phase. No new command is accepted during the write phase.

Top module: `dmem_stack_unit`

## Requirements
- R1: A direct access and an indirect access to any address 0x00–0x7F reach the same lower RAM byte.
- R2: An indirect access to 0x80–0xFF reaches upper RAM. A direct access to 0x80–0xFF reaches the register window and never upper RAM.
- R3: The stack pointer is the register at direct address 0x81 and resets to 0x07. Four general registers at direct addresses 0xF0–0xF3 reset to 0x00. All of these are readable and writable.
- R4: A direct access to any other address in 0x80–0xFF reads 0x00. A write to such an address changes no register and no RAM byte.
- R5: A push first reads its direct source byte, then adds one to the stack pointer, then stores the byte in RAM at the new pointer value through an indirect access. A pointer above 0x7F therefore stores into upper RAM.
- R6: A pop reads RAM at the current pointer and writes that byte to its direct destination, then subtracts one from the pointer. When the destination is 0x81, the popped byte becomes the new pointer value and no decrement follows.
- R7: The stack pointer counts modulo 256. A push at 0xFF gives 0x00, and a pop at 0x00 gives 0xFF.
- R8: A move copies the byte at the source (addr_a with mode_a) to the destination (addr_b with mode_b). A mode bit of 1 means indirect and 0 means direct.
- R9: Command codes are 0 read, 1 write, 2 move, 3 push and 4 pop. For a read or a write, rsp_valid pulses in the cycle after acceptance. For a move, push or pop, req_ready is low for one cycle and rsp_valid pulses two cycles after acceptance. rsp_data carries the byte that was read, written or transferred.
- R10: Codes 5–7 are accepted. They produce no response and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Unit idle; a command is taken when both are high |
| req_op | input | 3 | Command code |
| addr_a | input | 8 | Read/write address, move source, push source, pop destination |
| mode_a | input | 1 | Addressing mode of addr_a (1 = indirect) for read, write and move |
| addr_b | input | 8 | Move destination |
| mode_b | input | 1 | Addressing mode of addr_b (1 = indirect) |
| wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Byte read, written or transferred |

## Verification
Several internal faults show up at the ports quickly. A stack pointer with the wrong value or the wrong update order sends the next push or pop to the wrong RAM byte. The bench catches this on the next read of 0x81 or of the stack slot. A swapped alias decode changes the data returned by the very next direct or indirect access above 0x7F. A fault in the phase sequencer moves the rsp_valid pulse or the req_ready drop by a cycle, and the bench checks these signals after every command.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_MOVE  = 3'd2,
        OP_PUSH  = 3'd3,
        OP_POP   = 3'd4
    } op_e;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_WRITE = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e            phase;
        logic [2:0]        op;
        logic [ADDR_W-1:0] dst_addr;
        logic              dst_ind;
        logic [DATA_W-1:0] tmp;
        logic [ADDR_W-1:0] sp;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
    } unit_state_t;
endpackage

// File: rtl/dmem_addr_map.sv
module dmem_addr_map #(
    parameter int ADDR_W   = 8,
    parameter int SP_ADDR  = 8'h81,
    parameter int GP_BASE  = 8'hF0,
    parameter int GP_COUNT = 4,
    parameter int GP_IDX_W = 2
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                indirect,
    output logic                to_ram,
    output logic                is_sp,
    output logic                is_gp,
    output logic [GP_IDX_W-1:0] gp_idx
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        to_ram = indirect || !addr[ADDR_W-1];
        is_sp  = !to_ram && (int'(addr) == SP_ADDR);
        is_gp  = !to_ram && (int'(addr) >= GP_BASE) && (int'(addr) < GP_BASE + GP_COUNT);
        offset = addr - ADDR_W'(GP_BASE);
        gp_idx = offset[GP_IDX_W-1:0];
    end
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/dmem_sfr_bank.sv
module dmem_sfr_bank #(
    parameter int DATA_W   = 8,
    parameter int GP_COUNT = 4,
    parameter int GP_IDX_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [GP_IDX_W-1:0] widx,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [GP_IDX_W-1:0] ridx,
    output logic [DATA_W-1:0]   rdata
);
    logic [DATA_W-1:0] regs_q [GP_COUNT];

    for (genvar g = 0; g < GP_COUNT; g++) begin : g_reg
        logic [DATA_W-1:0] reg_d;
        always_comb begin
            reg_d = regs_q[g];
            if (we && (int'(widx) == g)) begin
                reg_d = wdata;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= '0;
            else        regs_q[g] <= reg_d;
        end
    end

    assign rdata = regs_q[ridx];
endmodule

// File: rtl/dmem_stack_unit.sv
module dmem_stack_unit
    import dmem_pkg::*;
#(
    parameter int SP_RESET = 8'h07,
    parameter int SP_ADDR  = 8'h81,
    parameter int GP_BASE  = 8'hF0,
    parameter int GP_COUNT = 4,
    localparam int GP_IDX_W = (GP_COUNT > 1) ? $clog2(GP_COUNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic              mode_a,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              mode_b,
    input  logic [DATA_W-1:0] wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    unit_state_t q, d;

    logic              accept;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_ind;
    logic              rd_to_ram, rd_is_sp, rd_is_gp;
    logic [GP_IDX_W-1:0] rd_gp_idx;
    logic [DATA_W-1:0] ram_rdata, gp_rdata, rd_val;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic              wr_ind;
    logic [DATA_W-1:0] wr_data;
    logic              wr_to_ram, wr_is_sp, wr_is_gp;
    logic [GP_IDX_W-1:0] wr_gp_idx;
    logic [ADDR_W-1:0] sp_q;

    assign sp_q      = q.sp;
    assign req_ready = (q.phase == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign rsp_valid = q.rsp_valid;
    assign rsp_data  = q.rsp_data;

    // read side: pop reads the stack slot, push reads a direct source
    always_comb begin
        rd_addr = addr_a;
        rd_ind  = mode_a;
        if (req_op == OP_POP) begin
            rd_addr = q.sp;
            rd_ind  = 1'b1;
        end else if (req_op == OP_PUSH) begin
            rd_ind  = 1'b0;
        end
    end

    dmem_addr_map #(
        .ADDR_W(ADDR_W), .SP_ADDR(SP_ADDR), .GP_BASE(GP_BASE),
        .GP_COUNT(GP_COUNT), .GP_IDX_W(GP_IDX_W)
    ) u_rd_map (
        .addr(rd_addr), .indirect(rd_ind), .to_ram(rd_to_ram),
        .is_sp(rd_is_sp), .is_gp(rd_is_gp), .gp_idx(rd_gp_idx)
    );

    always_comb begin
        if (rd_to_ram)     rd_val = ram_rdata;
        else if (rd_is_sp) rd_val = q.sp;
        else if (rd_is_gp) rd_val = gp_rdata;
        else               rd_val = '0;
    end

    // write side: single write at accept, or the second phase of a transfer
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = addr_a;
        wr_ind  = mode_a;
        wr_data = wdata;
        if (q.phase == PH_WRITE) begin
            wr_en   = 1'b1;
            wr_addr = q.dst_addr;
            wr_ind  = q.dst_ind;
            wr_data = q.tmp;
        end else if (accept && req_op == OP_WRITE) begin
            wr_en   = 1'b1;
        end
    end

    dmem_addr_map #(
        .ADDR_W(ADDR_W), .SP_ADDR(SP_ADDR), .GP_BASE(GP_BASE),
        .GP_COUNT(GP_COUNT), .GP_IDX_W(GP_IDX_W)
    ) u_wr_map (
        .addr(wr_addr), .indirect(wr_ind), .to_ram(wr_to_ram),
        .is_sp(wr_is_sp), .is_gp(wr_is_gp), .gp_idx(wr_gp_idx)
    );

    dmem_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .we(wr_en && wr_to_ram), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(ram_rdata)
    );

    dmem_sfr_bank #(.DATA_W(DATA_W), .GP_COUNT(GP_COUNT), .GP_IDX_W(GP_IDX_W)) u_sfr (
        .clk(clk), .rst_n(rst_n), .we(wr_en && wr_is_gp), .widx(wr_gp_idx),
        .wdata(wr_data), .ridx(rd_gp_idx), .rdata(gp_rdata)
    );

    // next-state computation
    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        if (q.phase == PH_WRITE) begin
            d.phase     = PH_IDLE;
            d.rsp_valid = 1'b1;
            d.rsp_data  = q.tmp;
            if (q.op == OP_POP) begin
                d.sp = q.sp - 1'b1;
            end
        end else if (accept) begin
            d.op = req_op;
            unique case (req_op)
                OP_READ: begin
                    d.rsp_valid = 1'b1;
                    d.rsp_data  = rd_val;
                end
                OP_WRITE: begin
                    d.rsp_valid = 1'b1;
                    d.rsp_data  = wdata;
                end
                OP_MOVE: begin
                    d.phase    = PH_WRITE;
                    d.tmp      = rd_val;
                    d.dst_addr = addr_b;
                    d.dst_ind  = mode_b;
                end
                OP_PUSH: begin
                    d.phase    = PH_WRITE;
                    d.tmp      = rd_val;
                    d.sp       = q.sp + 1'b1;
                    d.dst_addr = q.sp + 1'b1;
                    d.dst_ind  = 1'b1;
                end
                OP_POP: begin
                    d.phase    = PH_WRITE;
                    d.tmp      = rd_val;
                    d.dst_addr = addr_a;
                    d.dst_ind  = 1'b0;
                end
                default: ;
            endcase
        end
        // a direct write to the pointer register takes priority over any update
        if (wr_en && wr_is_sp) begin
            d.sp = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.phase     <= PH_IDLE;
            q.sp        <= ADDR_W'(SP_RESET);
        end else begin
            q <= d;
        end
    end

    // R9: transfers hold the unit busy for one cycle, then respond
    a_r9_transfer_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_op == OP_MOVE || req_op == OP_PUSH || req_op == OP_POP)) |=> !req_ready);
    a_r9_transfer_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_op == OP_MOVE || req_op == OP_PUSH || req_op == OP_POP)) |=> ##1 rsp_valid);
    a_r9_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_op == OP_READ || req_op == OP_WRITE)) |=> rsp_valid);
    // R5: push moves the pointer up by one at acceptance
    a_r5_push_pre_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op == OP_PUSH) |=> (sp_q == $past(sp_q) + 8'd1));
    // R6: pop into anything but the pointer register decrements it
    a_r6_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_WRITE && q.op == OP_POP && !wr_is_sp) |=> (sp_q == $past(sp_q) - 8'd1));
    // R10: unused codes neither respond nor move the pointer
    a_r10_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_op > 3'd4) |=> (!rsp_valid && req_ready && $stable(sp_q)));
endmodule

// File: tb/dmem_stack_unit_bench.sv
module dmem_stack_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_op = '0;
    logic [7:0] addr_a = '0;
    logic       mode_a = 1'b0;
    logic [7:0] addr_b = '0;
    logic       mode_b = 1'b0;
    logic [7:0] wdata = '0;
    logic       rsp_valid;
    logic [7:0] rsp_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] m_ram [256];
    logic [7:0] m_gp [4];
    logic [7:0] m_sp;

    always #5 clk = ~clk;

    dmem_stack_unit u_dmem_stack_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .addr_a(addr_a), .mode_a(mode_a), .addr_b(addr_b),
        .mode_b(mode_b), .wdata(wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    function automatic logic [7:0] m_read(input logic [7:0] a, input logic ind);
        if (ind || a < 8'h80)            return m_ram[a];
        if (a == 8'h81)                  return m_sp;
        if (a >= 8'hF0 && a <= 8'hF3)    return m_gp[a - 8'hF0];
        return 8'h00;
    endfunction

    task automatic m_write(input logic [7:0] a, input logic ind, input logic [7:0] v);
        if (ind || a < 8'h80)            m_ram[a] = v;
        else if (a == 8'h81)             m_sp = v;
        else if (a >= 8'hF0 && a <= 8'hF3) m_gp[a - 8'hF0] = v;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [7:0] a, input logic ma,
                         input logic [7:0] b, input logic mb, input logic [7:0] wd,
                         input string req);
        logic [7:0] v;
        bit multi;
        v = 8'h00;
        multi = (op == 3'd2 || op == 3'd3 || op == 3'd4);
        case (op)
            3'd0: v = m_read(a, ma);
            3'd1: begin v = wd; m_write(a, ma, wd); end
            3'd2: begin v = m_read(a, ma); m_write(b, mb, v); end
            3'd3: begin v = m_read(a, 1'b0); m_sp = m_sp + 8'd1; m_ram[m_sp] = v; end
            3'd4: begin
                v = m_ram[m_sp];
                if (a == 8'h81) m_sp = v;
                else begin m_write(a, 1'b0, v); m_sp = m_sp - 8'd1; end
            end
            default: ;
        endcase
        @(negedge clk);
        req_op = op; addr_a = a; mode_a = ma; addr_b = b; mode_b = mb; wdata = wd;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (op > 3'd4) begin
            check(!rsp_valid && req_ready, "R10 quiet", {rsp_valid, req_ready}, 2'b01);
        end else if (multi) begin
            check(!rsp_valid && !req_ready, "R9 busy phase", {rsp_valid, req_ready}, 2'b00);
            @(negedge clk);
            check(rsp_valid && req_ready, "R9 late rsp", {rsp_valid, req_ready}, 2'b11);
            check(rsp_data == v, req, rsp_data, v);
        end else begin
            check(rsp_valid, "R9 single rsp", rsp_valid, 1);
            check(rsp_data == v, req, rsp_data, v);
        end
    endtask

    function automatic string op_req(input logic [2:0] op);
        case (op)
            3'd0: return "R2 read";
            3'd1: return "R1 write";
            3'd2: return "R8 move";
            3'd3: return "R5 push";
            3'd4: return "R6 pop";
            default: return "R10 unused";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 4; i++) m_gp[i] = 8'h00;
        m_sp = 8'h07;
        repeat (3) @(negedge clk);
        check(req_ready && !rsp_valid, "R9 reset outputs", {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        do_op(3'd0, 8'h81, 1'b0, 8'h00, 1'b0, 8'h00, "R3 reset sp");
        do_op(3'd0, 8'hF0, 1'b0, 8'h00, 1'b0, 8'h00, "R3 reset gp");
        for (int i = 0; i < 256; i++)
            do_op(3'd1, 8'(i), 1'b1, 8'h00, 1'b0, 8'(i) ^ 8'h5A, "R2 fill");
        // R1 lower alias
        do_op(3'd1, 8'h10, 1'b0, 8'h00, 1'b0, 8'hAB, "R1 direct write");
        do_op(3'd0, 8'h10, 1'b1, 8'h00, 1'b0, 8'h00, "R1 indirect read");
        // R2 upper split
        do_op(3'd1, 8'h90, 1'b1, 8'h00, 1'b0, 8'h33, "R2 indirect write");
        do_op(3'd0, 8'h90, 1'b0, 8'h00, 1'b0, 8'h00, "R2 direct sees sfr");
        do_op(3'd1, 8'hF1, 1'b0, 8'h00, 1'b0, 8'h44, "R3 gp write");
        do_op(3'd0, 8'hF1, 1'b1, 8'h00, 1'b0, 8'h00, "R2 upper ram kept");
        do_op(3'd0, 8'hF1, 1'b0, 8'h00, 1'b0, 8'h00, "R3 gp read");
        // R4 unimplemented register
        do_op(3'd1, 8'hA0, 1'b0, 8'h00, 1'b0, 8'h77, "R4 ignored write");
        do_op(3'd0, 8'hA0, 1'b0, 8'h00, 1'b0, 8'h00, "R4 reads zero");
        do_op(3'd0, 8'hA0, 1'b1, 8'h00, 1'b0, 8'h00, "R4 ram untouched");
        // R5 push across 0x7F into upper RAM
        do_op(3'd1, 8'h81, 1'b0, 8'h00, 1'b0, 8'h7F, "R3 sp write");
        do_op(3'd3, 8'h10, 1'b0, 8'h00, 1'b0, 8'h00, "R5 push");
        do_op(3'd0, 8'h81, 1'b0, 8'h00, 1'b0, 8'h00, "R5 sp after push");
        do_op(3'd0, 8'h80, 1'b1, 8'h00, 1'b0, 8'h00, "R5 slot in upper ram");
        do_op(3'd0, 8'h80, 1'b0, 8'h00, 1'b0, 8'h00, "R5 sfr at 0x80 untouched");
        // R6 pop
        do_op(3'd4, 8'h20, 1'b0, 8'h00, 1'b0, 8'h00, "R6 pop");
        do_op(3'd0, 8'h20, 1'b0, 8'h00, 1'b0, 8'h00, "R6 pop destination");
        do_op(3'd0, 8'h81, 1'b0, 8'h00, 1'b0, 8'h00, "R6 sp after pop");
        // R7 wrap
        do_op(3'd1, 8'h81, 1'b0, 8'h00, 1'b0, 8'hFF, "R7 sp set");
        do_op(3'd3, 8'hF1, 1'b0, 8'h00, 1'b0, 8'h00, "R7 push wrap");
        do_op(3'd0, 8'h81, 1'b0, 8'h00, 1'b0, 8'h00, "R7 sp is zero");
        do_op(3'd0, 8'h00, 1'b1, 8'h00, 1'b0, 8'h00, "R7 slot zero");
        do_op(3'd4, 8'h30, 1'b0, 8'h00, 1'b0, 8'h00, "R7 pop wrap");
        do_op(3'd0, 8'h81, 1'b0, 8'h00, 1'b0, 8'h00, "R7 sp is ff");
        // R6 pop into the pointer
        do_op(3'd1, 8'h81, 1'b0, 8'h00, 1'b0, 8'h40, "R6 sp set");
        do_op(3'd1, 8'h40, 1'b1, 8'h00, 1'b0, 8'h66, "R6 slot set");
        do_op(3'd4, 8'h81, 1'b0, 8'h00, 1'b0, 8'h00, "R6 pop into sp");
        do_op(3'd0, 8'h81, 1'b0, 8'h00, 1'b0, 8'h00, "R6 sp holds popped");
        // R8 moves with mixed modes
        do_op(3'd2, 8'hC0, 1'b1, 8'hF2, 1'b0, 8'h00, "R8 move ind to dir");
        do_op(3'd0, 8'hF2, 1'b0, 8'h00, 1'b0, 8'h00, "R8 dest sfr");
        do_op(3'd2, 8'hF2, 1'b0, 8'hD0, 1'b1, 8'h00, "R8 move dir to ind");
        do_op(3'd0, 8'hD0, 1'b1, 8'h00, 1'b0, 8'h00, "R8 dest ram");
        // R10 unused code
        do_op(3'd5, 8'h81, 1'b0, 8'h00, 1'b0, 8'h12, "R10 unused");
        do_op(3'd0, 8'h81, 1'b0, 8'h00, 1'b0, 8'h00, "R10 sp unchanged");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] op;
            op = 3'($urandom % 6);
            if (op == 3'd5) op = 3'($urandom % 3) + 3'd5;
            do_op(op, 8'($urandom), 1'($urandom), 8'($urandom), 1'($urandom),
                  8'($urandom), op_req(op));
        end
        for (int i = 0; i < 256; i++)
            do_op(3'd0, 8'(i), 1'b1, 8'h00, 1'b0, 8'h00, "R2 final sweep");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule